// File: doc/BRIEF.md
# Hot-Plug Slot Control and Status Registers

This block holds the two 16-bit registers through which software manages one hot-plug slot of a downstream port. A small register bus selects either the control register or the status register. Software writes the control register to set two indicator codes, switch slot power and pulse the electromechanical interlock. The bus reads back the live slot levels and a set of latched events from the status register.

Five slot inputs pass through a synchronizer: attention button, power fault, retention-latch sensor, card presence and interlock state. Edges on these inputs latch into event bits, and software clears an event by writing a one to its bit. Each write to the control register counts as a command. A programmable number of cycles after the write, a command-completed event is raised. A single interrupt line combines every event with its enable.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset the control register reads 0x07C0, the status register reads 0x0000 when all inputs are low, both indicator outputs are 11 (off), slot power is disabled, and irq and emi_toggle are low.
- R2: In the status register, writing a 1 to any of bits 0 to 4 clears that event. Writing a 0 to an event bit leaves it as it was.
- R3: When an event is detected in the same cycle that software clears that bit, the bit stays set.
- R4: Status bits 5, 6 and 7 show the synchronized latch-sensor, presence and interlock levels. These bits cannot be written.
- R5: A rising edge of the synchronized attention button sets event bit 0, and its falling edge sets nothing. Any edge of the latch sensor sets bit 2. Any edge of presence sets bit 3. The interlock level sets no event. An input change shows as an event three clock edges after it is applied, with two synchronizer stages.
- R6: A rising edge of power fault sets event bit 1. While the fault is high and control bit 10 is 1 (slot off), bit 1 is set again in every cycle, so software cannot clear it. Once power is on, a clear takes effect.
- R7: Control bits 7:6 drive attn_ind and bits 9:8 drive pwr_ind. The codes are 01 on, 10 blink and 11 off. Writing code 00 leaves the output unchanged, but the register reads back the 00 that was written.
- R8: Control bit 10 set to 0 enables slot power and set to 1 disables it. slot_pwr_en follows on the clock edge of the write.
- R9: Writing 1 to control bit 11 gives emi_toggle a pulse of exactly one cycle after the write edge. Bit 11 always reads 0.
- R10: Status bit 4 sets exactly CMD_LATENCY cycles after the clock edge of the most recent control write. A new control write made before completion restarts the count.
- R11: With CMD_CPL_EN = 0, status bit 4 never sets.
- R12: irq is high exactly when control bit 5 is 1 and at least one event bit 0 to 4 is set together with its enable in control bits 0 to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_sel | input | 1 | Register select: 0 selects control, 1 selects status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| attn_btn | input | 1 | Attention button level |
| pwr_fault | input | 1 | Power fault level |
| mrl_sense | input | 1 | Retention-latch sensor level |
| prsnt_det | input | 1 | Card presence level |
| emi_engaged | input | 1 | Interlock engaged level |
| attn_ind | output | 2 | Attention indicator code |
| pwr_ind | output | 2 | Power indicator code |
| slot_pwr_en | output | 1 | Slot power enable |
| emi_toggle | output | 1 | One-cycle interlock toggle pulse |
| irq | output | 1 | Slot interrupt |

## Verification
Two functions can meet in one cycle: the detection of a new slot event and a software write that clears the same status bit. The bench forces this meeting. It applies the attention button level, then places the clearing status write on the third clock edge, which is the edge that registers the synchronized rise. It then reads the bit back and expects it still set. The command timer meets a similar overlap when a second control write arrives while a command is pending. The bench checks that completion does not appear at the first command's deadline and does appear exactly CMD_LATENCY cycles after the second write.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;

    // synchronized input lanes
    localparam int IN_N   = 5;
    localparam int IN_BTN = 0;
    localparam int IN_PF  = 1;
    localparam int IN_MRL = 2;
    localparam int IN_PRS = 3;
    localparam int IN_EMI = 4;

    // status event bits (software decodes these positions)
    localparam int EV_N   = 5;
    localparam int EV_BTN = 0;
    localparam int EV_PF  = 1;
    localparam int EV_MRL = 2;
    localparam int EV_PRS = 3;
    localparam int EV_CC  = 4;

    // control field positions
    localparam int CT_HP_IE   = 5;
    localparam int CT_ATTN_LO = 6;
    localparam int CT_PWR_LO  = 8;
    localparam int CT_PWR_OFF = 10;
    localparam int CT_EMI     = 11;
    localparam int CT_STORED  = 11;

    localparam logic [15:0] CTRL_RESET = 16'h07C0;

    typedef enum logic [1:0] {
        IND_RSVD  = 2'b00,
        IND_ON    = 2'b01,
        IND_BLINK = 2'b10,
        IND_OFF   = 2'b11
    } ind_code_e;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [CT_STORED-1:0] ctrl;
        logic [1:0]           attn;
        logic [1:0]           pwr;
        logic                 emi;
    } slot_ctl_t;

endpackage

// File: rtl/hp_slot_sync.sv
`timescale 1ns/1ps
module hp_slot_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);

    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] prev_q, prev_d;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
        prev_d = stg_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
            prev_q <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
            prev_q <= prev_d;
        end
    end

    assign lvl      = stg_q[STAGES-1];
    assign lvl_prev = prev_q;

    // R5: the delayed copy trails the synchronized level by one cycle
    a_r5_prev_trails: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_prev == $past(lvl)));

endmodule

// File: rtl/hp_slot_cmd_timer.sv
`timescale 1ns/1ps
module hp_slot_cmd_timer #(
    parameter int LATENCY = 8,
    parameter bit ENABLE  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LOAD = CW'(LATENCY - 1);

    generate
        if (ENABLE) begin : g_on
            typedef struct packed {
                logic          busy;
                logic [CW-1:0] cnt;
            } tmr_t;

            tmr_t tmr_q, tmr_d;
            logic done_c;

            always_comb begin
                tmr_d  = tmr_q;
                done_c = 1'b0;
                if (start) begin
                    tmr_d.busy = 1'b1;
                    tmr_d.cnt  = LOAD;
                end else if (tmr_q.busy) begin
                    if (tmr_q.cnt == '0) begin
                        tmr_d.busy = 1'b0;
                        done_c     = 1'b1;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt - 1'b1;
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    tmr_q <= '0;
                end else begin
                    tmr_q <= tmr_d;
                end
            end

            assign done = done_c;

            // R10: a command start always leaves the timer pending
            a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> tmr_q.busy);
            // R10: completion is a single-cycle event per command
            a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
                done |=> !done);
        end else begin : g_off
            logic unused_start;
            assign unused_start = start;
            assign done         = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/hp_slot_events.sv
`timescale 1ns/1ps
module hp_slot_events #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] ev
);

    logic [N-1:0] ev_q, ev_d;

    always_comb begin
        ev_d = (ev_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign ev = ev_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chk
            // R3: a detection is never lost to a simultaneous clear
            a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                set[i] |=> ev_q[i]);
            // R2: a one written without a new event clears the bit
            a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !set[i]) |=> !ev_q[i]);
            // R2: a set bit survives when not written with a one
            a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_q[i] && !clr[i]) |=> ev_q[i]);
        end
    endgenerate

endmodule

// File: rtl/hp_slot_regs.sv
`timescale 1ns/1ps
module hp_slot_regs
    import hp_slot_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CMD_LATENCY = 8,
    parameter bit CMD_CPL_EN  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        attn_btn,
    input  logic        pwr_fault,
    input  logic        mrl_sense,
    input  logic        prsnt_det,
    input  logic        emi_engaged,
    output logic [1:0]  attn_ind,
    output logic [1:0]  pwr_ind,
    output logic        slot_pwr_en,
    output logic        emi_toggle,
    output logic        irq
);

    logic [IN_N-1:0] raw_in, lvl, lvl_prev;
    logic [EV_N-1:0] ev_set, ev_clr, ev;
    logic            wr_ctrl, wr_stat, cc_done, slot_off;
    slot_ctl_t       st_q, st_d;
    logic [3:0]      unused_wbits;
    logic            unused_prev_emi;

    assign raw_in[IN_BTN] = attn_btn;
    assign raw_in[IN_PF]  = pwr_fault;
    assign raw_in[IN_MRL] = mrl_sense;
    assign raw_in[IN_PRS] = prsnt_det;
    assign raw_in[IN_EMI] = emi_engaged;

    assign unused_wbits    = reg_wdata[15:12];
    assign unused_prev_emi = lvl_prev[IN_EMI];

    hp_slot_sync #(
        .WIDTH  (IN_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (raw_in),
        .lvl      (lvl),
        .lvl_prev (lvl_prev)
    );

    assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);
    assign wr_stat = reg_wr && (reg_sel == SEL_STAT);

    hp_slot_cmd_timer #(
        .LATENCY (CMD_LATENCY),
        .ENABLE  (CMD_CPL_EN)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (wr_ctrl),
        .done  (cc_done)
    );

    // control register and indicator / power / interlock outputs
    always_comb begin
        st_d     = st_q;
        st_d.emi = 1'b0;
        if (wr_ctrl) begin
            st_d.ctrl = reg_wdata[CT_STORED-1:0];
            if (reg_wdata[CT_ATTN_LO +: 2] != IND_RSVD) begin
                st_d.attn = reg_wdata[CT_ATTN_LO +: 2];
            end
            if (reg_wdata[CT_PWR_LO +: 2] != IND_RSVD) begin
                st_d.pwr = reg_wdata[CT_PWR_LO +: 2];
            end
            st_d.emi = reg_wdata[CT_EMI];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RESET[CT_STORED-1:0];
            st_q.attn <= IND_OFF;
            st_q.pwr  <= IND_OFF;
            st_q.emi  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot_off = st_q.ctrl[CT_PWR_OFF];

    // event detection
    always_comb begin
        ev_set         = '0;
        ev_set[EV_BTN] = lvl[IN_BTN] & ~lvl_prev[IN_BTN];
        ev_set[EV_PF]  = (lvl[IN_PF] & ~lvl_prev[IN_PF]) | (lvl[IN_PF] & slot_off);
        ev_set[EV_MRL] = lvl[IN_MRL] ^ lvl_prev[IN_MRL];
        ev_set[EV_PRS] = lvl[IN_PRS] ^ lvl_prev[IN_PRS];
        ev_set[EV_CC]  = cc_done;
        ev_clr         = wr_stat ? reg_wdata[EV_N-1:0] : '0;
    end

    hp_slot_events #(
        .N (EV_N)
    ) u_events (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_set),
        .clr   (ev_clr),
        .ev    (ev)
    );

    // read mux
    always_comb begin
        if (reg_sel == SEL_CTRL) begin
            reg_rdata = {{(16-CT_STORED){1'b0}}, st_q.ctrl};
        end else begin
            reg_rdata = {8'h00, lvl[IN_EMI], lvl[IN_PRS], lvl[IN_MRL], ev};
        end
    end

    assign attn_ind    = st_q.attn;
    assign pwr_ind     = st_q.pwr;
    assign slot_pwr_en = ~slot_off;
    assign emi_toggle  = st_q.emi;
    assign irq         = st_q.ctrl[CT_HP_IE] & (|(ev & st_q.ctrl[EV_N-1:0]));

    // R7: a reserved code leaves the indicator as it was
    a_r7_attn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[CT_ATTN_LO +: 2] == IND_RSVD) |=> $stable(attn_ind));
    a_r7_pwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[CT_PWR_LO +: 2] == IND_RSVD) |=> $stable(pwr_ind));
    // R8: power enable follows the written control bit
    a_r8_pwr_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (slot_pwr_en == !$past(reg_wdata[CT_PWR_OFF])));
    // R9: interlock toggle is a single pulse per request
    a_r9_emi_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[CT_EMI]) |=> emi_toggle);
    a_r9_emi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl && reg_wdata[CT_EMI]) |=> !emi_toggle);
    // R6: a persisting fault on an unpowered slot keeps its event
    a_r6_pf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl[IN_PF] && slot_off) |=> ev[EV_PF]);
    // R12: no interrupt while the master enable is low
    a_r12_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl[CT_HP_IE] |-> !irq);

endmodule

// File: tb/tb_hp_slot_regs.sv
`timescale 1ns/1ps
module tb_hp_slot_regs;

    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata, rdata_nc;
    logic        attn_btn = 1'b0, pwr_fault = 1'b0, mrl_sense = 1'b0;
    logic        prsnt_det = 1'b0, emi_engaged = 1'b0;
    logic [1:0]  attn_ind, pwr_ind, attn_nc, pwr_nc;
    logic        slot_pwr_en, emi_toggle, irq, pe_nc, emi_nc, irq_nc;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hp_slot_regs #(.SYNC_STAGES(2), .CMD_LATENCY(LAT), .CMD_CPL_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .attn_btn(attn_btn), .pwr_fault(pwr_fault), .mrl_sense(mrl_sense),
        .prsnt_det(prsnt_det), .emi_engaged(emi_engaged),
        .attn_ind(attn_ind), .pwr_ind(pwr_ind), .slot_pwr_en(slot_pwr_en),
        .emi_toggle(emi_toggle), .irq(irq));

    hp_slot_regs #(.SYNC_STAGES(2), .CMD_LATENCY(LAT), .CMD_CPL_EN(1'b0)) dut_nc (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nc),
        .attn_btn(attn_btn), .pwr_fault(pwr_fault), .mrl_sense(mrl_sense),
        .prsnt_det(prsnt_det), .emi_engaged(emi_engaged),
        .attn_ind(attn_nc), .pwr_ind(pwr_nc), .slot_pwr_en(pe_nc),
        .emi_toggle(emi_nc), .irq(irq_nc));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        idle(LAT + 4);
        wr(1'b1, 16'h001F);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(1'b0, v); chk("R1 ctrl reset", v, 16'h07C0);
        rd(1'b1, v); chk("R1 status reset", v, 16'h0000);
        chk("R1 attn_ind", {14'd0, attn_ind}, 16'h3);
        chk("R1 pwr_ind", {14'd0, pwr_ind}, 16'h3);
        chk("R1 power/irq/emi", {13'd0, slot_pwr_en, irq, emi_toggle}, 16'h0);
    endtask

    task automatic t_button();
        logic [15:0] v;
        @(negedge clk); attn_btn = 1'b1;
        @(negedge clk);
        wr(1'b1, 16'h0001);              // clear lands on the detecting edge
        rd(1'b1, v); chk("R3 set wins over clear", v & 16'h1, 16'h1);
        wr(1'b1, 16'h0001);
        rd(1'b1, v); chk("R2 w1c clears bit0", v & 16'h1, 16'h0);
        attn_btn = 1'b0; idle(4);
        rd(1'b1, v); chk("R5 falling button no event", v & 16'h1, 16'h0);
        attn_btn = 1'b1; idle(4);
        wr(1'b1, 16'h001E);
        rd(1'b1, v); chk("R2 zero write keeps bit0", v & 16'h1, 16'h1);
        wr(1'b1, 16'h0001);
        attn_btn = 1'b0; idle(4);
    endtask

    task automatic t_levels();
        logic [15:0] v;
        mrl_sense = 1'b1; idle(2);
        rd(1'b1, v); chk("R5 event not before third edge", v & 16'h4, 16'h0);
        idle(1);
        rd(1'b1, v); chk("R5 mrl rise event + R4 live", v & 16'h24, 16'h24);
        wr(1'b1, 16'h0004);
        mrl_sense = 1'b0; idle(4);
        rd(1'b1, v); chk("R5 mrl fall event", v & 16'h24, 16'h04);
        wr(1'b1, 16'h0004);
        prsnt_det = 1'b1; idle(4);
        wr(1'b1, 16'hFFE0);
        rd(1'b1, v); chk("R4 live bits not writable", v & 16'h48, 16'h48);
        wr(1'b1, 16'h0008);
        emi_engaged = 1'b1; idle(4);
        rd(1'b1, v); chk("R4 emi live, R5 no emi event", v, 16'h00C0);
        emi_engaged = 1'b0; prsnt_det = 1'b0; idle(4);
        wr(1'b1, 16'h001F);
    endtask

    task automatic t_fault();
        logic [15:0] v;
        pwr_fault = 1'b1; idle(4);
        wr(1'b1, 16'h0002);
        rd(1'b1, v); chk("R6 fault sticky while off", v & 16'h2, 16'h2);
        wr(1'b0, 16'h03C0);
        chk("R8 power on", {15'd0, slot_pwr_en}, 16'h1);
        wr(1'b1, 16'h0002);
        rd(1'b1, v); chk("R6 clear once powered", v & 16'h2, 16'h0);
        pwr_fault = 1'b0;
        wr(1'b0, 16'h07C0);
        chk("R8 power off", {15'd0, slot_pwr_en}, 16'h0);
        settle();
    endtask

    task automatic t_indicators();
        logic [15:0] v;
        wr(1'b0, 16'h0640);
        chk("R7 attn on", {14'd0, attn_ind}, 16'h1);
        chk("R7 pwr blink", {14'd0, pwr_ind}, 16'h2);
        wr(1'b0, 16'h0400);
        chk("R7 reserved keeps attn", {14'd0, attn_ind}, 16'h1);
        chk("R7 reserved keeps pwr", {14'd0, pwr_ind}, 16'h2);
        rd(1'b0, v); chk("R7 readback of reserved", v, 16'h0400);
        wr(1'b0, 16'h07C0);
        chk("R7 both off", {12'd0, attn_ind, pwr_ind}, 16'hF);
        settle();
    endtask

    task automatic t_emi();
        logic [15:0] v;
        wr(1'b0, 16'h0FC0);
        chk("R9 pulse high", {15'd0, emi_toggle}, 16'h1);
        @(negedge clk);
        chk("R9 pulse one cycle", {15'd0, emi_toggle}, 16'h0);
        rd(1'b0, v); chk("R9 bit11 reads 0", v, 16'h07C0);
        settle();
    endtask

    task automatic t_cmd();
        logic [15:0] v;
        wr(1'b0, 16'h07C0);
        idle(LAT - 1);
        rd(1'b1, v); chk("R10 not early", v & 16'h10, 16'h0);
        idle(1);
        rd(1'b1, v); chk("R10 on time", v & 16'h10, 16'h10);
        wr(1'b1, 16'h0010);
        wr(1'b0, 16'h07C0);
        idle(4);
        wr(1'b0, 16'h07C0);
        idle(LAT - 1);
        rd(1'b1, v); chk("R10 restart no early completion", v & 16'h10, 16'h0);
        reg_sel = 1'b1; #1;
        chk("R11 disabled completion", rdata_nc & 16'h10, 16'h0);
        idle(1);
        rd(1'b1, v); chk("R10 restart completes", v & 16'h10, 16'h10);
        settle();
        reg_sel = 1'b1; #1;
        chk("R11 still clear later", rdata_nc & 16'h10, 16'h0);
    endtask

    task automatic t_irq();
        wr(1'b0, 16'h07E1);
        attn_btn = 1'b1; idle(4);
        chk("R12 enabled event raises irq", {15'd0, irq}, 16'h1);
        wr(1'b0, 16'h07C1);
        chk("R12 master enable gates irq", {15'd0, irq}, 16'h0);
        attn_btn = 1'b0;
        settle();
        wr(1'b0, 16'h07F0);
        chk("R12 no irq before completion", {15'd0, irq}, 16'h0);
        idle(LAT);
        chk("R12 completion irq", {15'd0, irq}, 16'h1);
        wr(1'b1, 16'h0010);
        chk("R12 irq drops on clear", {15'd0, irq}, 16'h0);
        wr(1'b0, 16'h07C0);
        settle();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_button();
        t_levels();
        t_fault();
        t_indicators();
        t_emi();
        t_cmd();
        t_irq();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule